// File: doc/BRIEF.md
# Column Pointer Pair Fetch

This block turns a column index into the two bounds that delimit that column's run of non-zero entries in a compressed sparse matrix. Column j starts at pointer p_j and ends at pointer p_{j+1}. The pointer table holds COLS+1 entries and is split across two single-ported banks. Pointers with an even index live in the even bank at address k/2. Pointers with an odd index live in the odd bank at address (k-1)/2. Any two neighbouring pointers therefore sit in different banks, so both bounds come back from one access to each bank.

A column index and its activation value arrive with a valid/ready handshake from the head of an activation queue. The block reads the even bank at (j+1)>>1 and the odd bank at j>>1. For an odd column it swaps the two results so that the start bound always comes out before the end bound. It presents the pair, the column, the activation and an empty-column flag in an output register that obeys valid/ready backpressure. A load port writes single pointers into the table. Because each bank has only one port, a load takes the bank for that cycle and the block accepts no column while a load is presented.

The control is a three-state machine:
- IDLE: the output register is empty and a column may be accepted.
- READ: the bank read is in flight.
- HOLD: the output register is valid.

Its transitions are:
- IDLE to READ on accept.
- READ to HOLD always.
- HOLD to IDLE when the output is taken and no new column is accepted.
- HOLD to READ when the output is taken and a new column is accepted in the same cycle.

Top module: `colptr_fetch`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 while ld_valid is 0.
- R2: A cycle with ld_valid high writes ld_data to pointer index ld_addr. The bank is chosen by ld_addr bit 0 (0 selects even, 1 selects odd) and the bank address is ld_addr>>1. A load with ld_addr greater than COLS changes no pointer.
- R3: For an even column j, out_start equals p_j and out_end equals p_{j+1}.
- R4: For an odd column j, out_start equals p_j and out_end equals p_{j+1}. This is the same order as for even columns, even though the start pointer then comes from the odd bank.
- R5: If a column is accepted at clock edge E, out_valid is 0 after E and 1 after E+1. At that point out_col and out_act carry the accepted index and activation.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1, all output fields keep their values, and in_ready is 0.
- R7: While ld_valid is 1, in_ready is 0 and no column is accepted.
- R8: out_empty is 1 exactly when out_start equals out_end.
- R9: In HOLD, with out_ready high, a new column is accepted in the same cycle the current output is taken. The new result follows with the latency given in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Write one pointer this cycle |
| ld_addr | input | PA_W | Pointer index to write (0..COLS) |
| ld_data | input | PTR_W | Pointer value to write |
| in_valid | input | 1 | Column request present |
| in_ready | output | 1 | Column request accepted this cycle when valid |
| in_col | input | IDX_W | Column index j |
| in_act | input | ACT_W | Activation value travelling with the column |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_start | output | PTR_W | Start bound p_j |
| out_end | output | PTR_W | End bound p_{j+1} |
| out_empty | output | 1 | Column has no entries (start equals end) |
| out_col | output | IDX_W | Column index of this result |
| out_act | output | ACT_W | Activation of this result |

## Verification
The bench builds the block with COLS=32 and 16-bit pointers and activations. With these values the even bank has 17 words and the odd bank has 16. The last column, 31, is odd and reads the top even word, index 32. Load indices 33 to 63 fit the 6-bit load address but name no pointer, so the out-of-range path of R2 can be reached. The random pointer tables use increments of 0 to 3, which gives a steady mix of empty and non-empty columns in both bank orders.

// File: rtl/colptr_pkg.sv
package colptr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_HOLD = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/colptr_bank.sv
module colptr_bank #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = ({1'b0, addr} < (AW+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= in_range ? mem[addr] : '0;
        end
    end
endmodule

// File: rtl/colptr_addr.sv
module colptr_addr #(
    parameter int IDX_W = 5,
    parameter int BA_W  = 5
) (
    input  logic [IDX_W-1:0] col,
    output logic [BA_W-1:0]  even_addr,
    output logic [BA_W-1:0]  odd_addr,
    output logic             swap
);
    logic [IDX_W:0] col_plus;

    assign col_plus  = {1'b0, col} + (IDX_W+1)'(1);
    assign even_addr = BA_W'(col_plus >> 1);
    assign odd_addr  = BA_W'(col >> 1);
    assign swap      = col[0];
endmodule

// File: rtl/colptr_fetch.sv
module colptr_fetch
    import colptr_pkg::*;
#(
    parameter int  COLS  = 32,
    parameter int  PTR_W = 16,
    parameter int  ACT_W = 16,
    localparam int IDX_W = $clog2(COLS),
    localparam int PA_W  = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [PA_W-1:0]  ld_addr,
    input  logic [PTR_W-1:0] ld_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_col,
    input  logic [ACT_W-1:0] in_act,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PTR_W-1:0] out_start,
    output logic [PTR_W-1:0] out_end,
    output logic             out_empty,
    output logic [IDX_W-1:0] out_col,
    output logic [ACT_W-1:0] out_act
);
    localparam int NPTR  = COLS + 1;
    localparam int EV_D  = (NPTR + 1) / 2;
    localparam int OD_D  = NPTR / 2;
    localparam int BA_W  = (EV_D > 1) ? $clog2(EV_D) : 1;

    fetch_state_t st_q, st_d;

    logic             accept;
    logic [BA_W-1:0]  rd_even, rd_odd;
    logic             rd_swap;
    logic             ld_hit;
    logic [BA_W-1:0]  ld_baddr;
    logic             bank_we   [2];
    logic             bank_re   [2];
    logic [BA_W-1:0]  bank_addr [2];
    logic [PTR_W-1:0] bank_rd   [2];
    logic             swap_q;
    logic [IDX_W-1:0] col_q;
    logic [ACT_W-1:0] act_q;
    logic [PTR_W-1:0] sel_start, sel_end;

    assign in_ready = !ld_valid &&
                      ((st_q == ST_IDLE) || ((st_q == ST_HOLD) && out_ready));
    assign accept   = in_valid && in_ready;

    colptr_addr #(.IDX_W(IDX_W), .BA_W(BA_W)) u_addr (
        .col       (in_col),
        .even_addr (rd_even),
        .odd_addr  (rd_odd),
        .swap      (rd_swap)
    );

    assign ld_hit   = ld_valid && ({1'b0, ld_addr} <= (PA_W+1)'(COLS));
    assign ld_baddr = BA_W'(ld_addr >> 1);

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam int DEP = (g == 0) ? EV_D : OD_D;
        assign bank_we[g]   = ld_hit && (ld_addr[0] == g[0]);
        assign bank_re[g]   = accept;
        assign bank_addr[g] = bank_we[g] ? ld_baddr : ((g == 0) ? rd_even : rd_odd);

        colptr_bank #(.DEPTH(DEP), .AW(BA_W), .DW(PTR_W)) u_bank (
            .clk   (clk),
            .we    (bank_we[g]),
            .re    (bank_re[g]),
            .addr  (bank_addr[g]),
            .wdata (ld_data),
            .rdata (bank_rd[g])
        );
    end

    assign sel_start = swap_q ? bank_rd[1] : bank_rd[0];
    assign sel_end   = swap_q ? bank_rd[0] : bank_rd[1];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_READ;
            ST_READ: st_d = ST_HOLD;
            ST_HOLD: begin
                if (out_ready) st_d = accept ? ST_READ : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swap_q    <= 1'b0;
            col_q     <= '0;
            act_q     <= '0;
            out_valid <= 1'b0;
            out_start <= '0;
            out_end   <= '0;
            out_empty <= 1'b0;
            out_col   <= '0;
            out_act   <= '0;
        end else begin
            if (accept) begin
                swap_q <= rd_swap;
                col_q  <= in_col;
                act_q  <= in_act;
            end
            unique case (st_q)
                ST_READ: begin
                    out_valid <= 1'b1;
                    out_start <= sel_start;
                    out_end   <= sel_end;
                    out_empty <= (sel_start == sel_end);
                    out_col   <= col_q;
                    out_act   <= act_q;
                end
                ST_HOLD: if (out_ready) out_valid <= 1'b0;
                default: ;
            endcase
        end
    end

    // R6: a stalled result holds all of its fields
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_start) &&
            $stable(out_end) && $stable(out_col) && $stable(out_act)));

    // R6: no accept while a result is stalled
    p_stall_noaccept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: a load blocks column acceptance
    p_load_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !in_ready);

    // R5: fixed two-edge latency from accept to valid output
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!out_valid ##1 out_valid));

    // R8: empty flag agrees with the bounds
    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_empty == (out_start == out_end)));

    // R2: each single-ported bank does one access per cycle
    p_even_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_we[0] && bank_re[0]));
    p_odd_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_we[1] && bank_re[1]));
endmodule

// File: tb/colptr_fetch_tb.sv
module colptr_fetch_tb;
    localparam int CLK_P = 10;
    localparam int COLS  = 32;
    localparam int PTR_W = 16;
    localparam int ACT_W = 16;
    localparam int IDX_W = $clog2(COLS);
    localparam int PA_W  = $clog2(COLS + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_valid = 1'b0;
    logic [PA_W-1:0]  ld_addr = '0;
    logic [PTR_W-1:0] ld_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IDX_W-1:0] in_col = '0;
    logic [ACT_W-1:0] in_act = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PTR_W-1:0] out_start, out_end;
    logic             out_empty;
    logic [IDX_W-1:0] out_col;
    logic [ACT_W-1:0] out_act;

    int checks = 0;
    int errors = 0;
    logic [PTR_W-1:0] model [COLS+1];

    always #(CLK_P/2) clk = ~clk;

    colptr_fetch #(.COLS(COLS), .PTR_W(PTR_W), .ACT_W(ACT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_col(in_col), .in_act(in_act), .out_valid(out_valid),
        .out_ready(out_ready), .out_start(out_start), .out_end(out_end),
        .out_empty(out_empty), .out_col(out_col), .out_act(out_act)
    );

    function automatic logic [PTR_W-1:0] f_start(int j);
        return model[j];
    endfunction
    function automatic logic [PTR_W-1:0] f_end(int j);
        return model[j+1];
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input int k, input logic [PTR_W-1:0] v);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = PA_W'(k);
        ld_data  = v;
        @(negedge clk);
        ld_valid = 1'b0;
        if (k <= COLS) model[k] = v;
    endtask

    task automatic check_result(input int j, input logic [ACT_W-1:0] a, input string tag);
        chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
        chk(out_start == f_start(j), {tag, " start"}, out_start, f_start(j));
        chk(out_end == f_end(j), {tag, " end"}, out_end, f_end(j));
        chk(out_empty == (f_start(j) == f_end(j)), "R8 empty", out_empty,
            f_start(j) == f_end(j));
        chk(out_col == IDX_W'(j), "R5 col", out_col, j);
        chk(out_act == a, "R5 act", out_act, a);
    endtask

    task automatic do_fetch(input int j, input logic [ACT_W-1:0] a, input int stall);
        string tag;
        tag = (j % 2 == 0) ? "R3" : "R4";
        @(negedge clk);
        in_valid  = 1'b1;
        in_col    = IDX_W'(j);
        in_act    = a;
        out_ready = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R5 not yet valid", out_valid, 0);
        @(negedge clk);
        check_result(j, a, tag);
        for (int s = 0; s < stall; s++) begin
            in_valid = 1'b1;
            @(negedge clk);
            chk(in_ready == 1'b0, "R6 ready low in stall", in_ready, 0);
            chk(out_valid && out_start == f_start(j) && out_end == f_end(j),
                "R6 held", out_start, f_start(j));
            in_valid = 1'b0;
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R6 drained", out_valid, 0);
    endtask

    task automatic do_b2b(input int j1, input int j2);
        @(negedge clk);
        in_valid = 1'b1; in_col = IDX_W'(j1); in_act = 16'h1111; out_ready = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_result(j1, 16'h1111, "R9 first");
        in_valid = 1'b1; in_col = IDX_W'(j2); in_act = 16'h2222; out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R9 ready while draining", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        chk(out_valid == 1'b0, "R9 read slot", out_valid, 0);
        @(negedge clk);
        check_result(j2, 16'h2222, "R9 second");
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic fill_random();
        logic [PTR_W-1:0] p;
        p = PTR_W'($urandom_range(0, 5));
        for (int k = 0; k <= COLS; k++) begin
            do_load(k, p);
            p = p + PTR_W'($urandom_range(0, 3));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        fill_random();
        // force one empty column, one non-empty
        do_load(4, 16'd100);
        do_load(5, 16'd100);
        do_load(6, 16'd107);
        do_fetch(4, 16'hA004, 0);
        do_fetch(5, 16'hA005, 2);
        do_fetch(0, 16'h0001, 0);
        do_fetch(1, 16'h0002, 1);
        do_fetch(COLS-1, 16'hBEEF, 0);
        do_fetch(COLS-2, 16'hCAFE, 3);

        // R2: out-of-range loads change nothing
        do_load(33, 16'hFFFF);
        do_load(34, 16'hEEEE);
        do_load(63, 16'hDDDD);
        do_fetch(COLS-1, 16'h0031, 0);
        do_fetch(0, 16'h0030, 0);
        do_fetch(16, 16'h0016, 0);
        do_fetch(15, 16'h0015, 0);
        // R2: in-range overwrite is seen
        do_load(COLS, 16'h7000);
        do_fetch(COLS-1, 16'h0032, 0);

        // R7: load blocks acceptance
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = PA_W'(7); ld_data = model[7];
        in_valid = 1'b1; in_col = IDX_W'(7);
        #1;
        chk(in_ready == 1'b0, "R7 ready low during load", in_ready, 0);
        @(negedge clk);
        ld_valid = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R7 no accept", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 no result", out_valid, 0);

        do_b2b(2, 3);
        do_b2b(9, 20);

        fill_random();
        for (int n = 0; n < 40; n++) begin
            do_fetch(int'($urandom_range(0, COLS-1)), ACT_W'($urandom),
                     int'($urandom_range(0, 2)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule